// File: doc/BRIEF.md
# Root Port Interrupt and Error Message Queue

This block sits beside a PCI Express root port and buffers the interrupt traffic that arrives from downstream. Legacy wire interrupts (one of four lines) and message-signalled interrupts share one first-in first-out queue. Received error messages (correctable, non-fatal, fatal) go into a second, smaller queue. The upstream logic delivers each entry as a single-cycle push strobe that carries the entry fields. The block does not decode link-layer messages.

Software reads the head of each queue through a fixed register window. A read returns the head entry packed into register bits together with a valid flag. Any write to the same register removes that head entry. Each accepted push also sends a one-cycle event pulse toward the interrupt decode logic: one pulse for a wire interrupt, one for an MSI, and one pulse per error class. If a push arrives while its queue is full, the entry is dropped and a sticky overflow flag is raised.

Top module: `rp_msg_queue`

## Requirements
- R1: After reset both queues are empty. Reads at 0x158, 0x15C and 0x154 return zero. All event pulses and both overflow flags are low.
- R2: A read at offset 0x158 returns the interrupt queue head. Bit 31 is the valid flag, bit 30 is 1 for an MSI and 0 for a wire interrupt, and bits 28:27 hold the wire interrupt line (0 to 3). All other bits read zero.
- R3: A read at offset 0x15C returns the 16-bit MSI message data in bits 15:0 when the interrupt head is a valid MSI entry. Otherwise it returns zero.
- R4: A write of any value to offset 0x158 removes the interrupt head entry. Entries leave the queue in the order they arrived.
- R5: A read at offset 0x154 returns the error queue head. Bit 18 is valid, bits 17:16 hold the class (0 correctable, 1 non-fatal, 2 fatal, 3 treated as fatal) and bits 15:0 hold the requester ID. A write of any value to 0x154 removes the head. Order is first-in first-out.
- R6: A removal write to an empty queue has no effect. The valid bit stays zero, and a later push becomes the head normally.
- R7: The interrupt queue holds 8 entries and the error queue holds 4. A push to a full queue is dropped and sets that queue's sticky overflow flag. Only reset clears the flag, and the stored entries are unchanged.
- R8: A push that arrives in the same cycle as a removal from a full queue is accepted, and no overflow is recorded.
- R9: An accepted push raises exactly one event output for one cycle, in the cycle after the push: the wire or MSI event for the interrupt queue, or the event bit for the error class (bit 0 correctable, bit 1 non-fatal, bit 2 fatal). A dropped push raises no event.
- R10: Writes to any other offset, including 0x15C, remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_push | input | 1 | Push strobe for the interrupt queue |
| irq_is_msi | input | 1 | 1 = MSI entry, 0 = wire interrupt |
| irq_line | input | 2 | Wire interrupt line number |
| irq_data | input | 16 | MSI message data |
| err_push | input | 1 | Push strobe for the error queue |
| err_class | input | 2 | Error class code |
| err_rid | input | 16 | Requester ID of the error message |
| bus_addr | input | 12 | Register offset for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_intx | output | 1 | Wire interrupt event pulse |
| ev_msi | output | 1 | MSI event pulse |
| ev_err | output | 3 | Error event pulses by class |
| irq_ovf | output | 1 | Sticky interrupt queue overflow |
| err_ovf | output | 1 | Sticky error queue overflow |

## Verification
The hardest case to reach is a push and a removal landing in the same cycle while the queue is exactly full. Hitting it requires filling the queue to its last slot first, and then driving the push strobe and the register write on the same clock edge. The bench builds this state with a run of eight pushes. It then checks that the overflow flag stays low and that the new entry drains last, behind the seven older ones. Pushing past capacity is then repeated to confirm that the flag stays set after the queue has drained.

// File: rtl/rp_msgq_pkg.sv
package rp_msgq_pkg;

    localparam int unsigned REG_ADDR_W = 12;

    localparam logic [REG_ADDR_W-1:0] OFS_ERR_HEAD = 12'h154;
    localparam logic [REG_ADDR_W-1:0] OFS_IRQ_HEAD = 12'h158;
    localparam logic [REG_ADDR_W-1:0] OFS_IRQ_DATA = 12'h15C;

    localparam int unsigned IRQ_VALID_BIT = 31;
    localparam int unsigned IRQ_MSI_BIT   = 30;
    localparam int unsigned IRQ_LINE_LSB  = 27;
    localparam int unsigned ERR_VALID_BIT = 18;
    localparam int unsigned ERR_CLASS_LSB = 16;

    localparam int unsigned NUM_ERR_EV = 3;

    typedef enum logic [1:0] {
        ERR_COR      = 2'd0,
        ERR_NONFATAL = 2'd1,
        ERR_FATAL    = 2'd2,
        ERR_FATAL_X  = 2'd3
    } err_class_e;

    typedef struct packed {
        logic        is_msi;
        logic [1:0]  line;
        logic [15:0] data;
    } irq_entry_t;

    typedef struct packed {
        err_class_e  cls;
        logic [15:0] rid;
    } err_entry_t;

    function automatic logic [31:0] pack_irq_head(input logic vld, input irq_entry_t e);
        logic [31:0] r;
        r = '0;
        if (vld) begin
            r[IRQ_VALID_BIT] = 1'b1;
            r[IRQ_MSI_BIT]   = e.is_msi;
            r[IRQ_LINE_LSB +: 2] = e.is_msi ? 2'b00 : e.line;
        end
        return r;
    endfunction

    function automatic logic [31:0] pack_irq_data(input logic vld, input irq_entry_t e);
        return (vld && e.is_msi) ? {16'h0000, e.data} : 32'h0;
    endfunction

    function automatic logic [31:0] pack_err_head(input logic vld, input err_entry_t e);
        logic [31:0] r;
        r = '0;
        if (vld) begin
            r[ERR_VALID_BIT]       = 1'b1;
            r[ERR_CLASS_LSB +: 2]  = e.cls;
            r[15:0]                = e.rid;
        end
        return r;
    endfunction

    function automatic int unsigned class_to_event(input err_class_e c);
        case (c)
            ERR_COR:      return 0;
            ERR_NONFATAL: return 1;
            default:      return 2;
        endcase
    endfunction

endpackage

// File: rtl/rp_msg_fifo.sv
module rp_msg_fifo #(
    parameter int unsigned WIDTH = 19,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             head_valid,
    output logic             accepted,
    output logic             overflow
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             pop_ok, push_ok;

    assign pop_ok   = pop && (count != '0);
    assign push_ok  = push && ((count != FULL) || pop_ok);
    assign accepted = push_ok;
    assign head       = mem[rd_ptr];
    assign head_valid = (count != '0);

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !push_ok) overflow <= 1'b1;
        end
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_empty_pop_noop_R6: assert property (@(posedge clk) disable iff (rst)
        (!head_valid && pop && !push) |=> !head_valid);

    assert_full_pop_push_R8: assert property (@(posedge clk) disable iff (rst)
        (count == FULL && pop && push) |=> (count == FULL));

endmodule

// File: rtl/rp_msg_regs.sv
module rp_msg_regs
    import rp_msgq_pkg::*;
(
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  irq_vld,
    input  irq_entry_t            irq_head,
    input  logic                  err_vld,
    input  err_entry_t            err_head,
    output logic [31:0]           rdata,
    output logic                  irq_pop,
    output logic                  err_pop
);
    always_comb begin
        case (bus_addr)
            OFS_IRQ_HEAD: rdata = pack_irq_head(irq_vld, irq_head);
            OFS_IRQ_DATA: rdata = pack_irq_data(irq_vld, irq_head);
            OFS_ERR_HEAD: rdata = pack_err_head(err_vld, err_head);
            default:      rdata = 32'h0;
        endcase
    end

    assign irq_pop = bus_wr && (bus_addr == OFS_IRQ_HEAD);
    assign err_pop = bus_wr && (bus_addr == OFS_ERR_HEAD);

    always_comb begin
        assert_pops_exclusive_R10: assert (!(irq_pop && err_pop));
    end

endmodule

// File: rtl/rp_msg_queue.sv
module rp_msg_queue
    import rp_msgq_pkg::*;
#(
    parameter int unsigned IRQ_DEPTH = 8,
    parameter int unsigned ERR_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  irq_push,
    input  logic                  irq_is_msi,
    input  logic [1:0]            irq_line,
    input  logic [15:0]           irq_data,
    input  logic                  err_push,
    input  logic [1:0]            err_class,
    input  logic [15:0]           err_rid,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    output logic [31:0]           bus_rdata,
    output logic                  ev_intx,
    output logic                  ev_msi,
    output logic [NUM_ERR_EV-1:0] ev_err,
    output logic                  irq_ovf,
    output logic                  err_ovf
);
    localparam int unsigned IRQ_W = $bits(irq_entry_t);
    localparam int unsigned ERR_W = $bits(err_entry_t);

    irq_entry_t irq_in, irq_head;
    err_entry_t err_in, err_head;
    logic [IRQ_W-1:0] irq_head_raw;
    logic [ERR_W-1:0] err_head_raw;
    logic irq_vld, err_vld, irq_pop, err_pop, irq_acc, err_acc;

    assign irq_in   = '{is_msi: irq_is_msi, line: irq_line, data: irq_data};
    assign err_in   = '{cls: err_class_e'(err_class), rid: err_rid};
    assign irq_head = irq_entry_t'(irq_head_raw);
    assign err_head = err_entry_t'(err_head_raw);

    rp_msg_fifo #(.WIDTH(IRQ_W), .DEPTH(IRQ_DEPTH)) u_irq_q (
        .clk(clk), .rst(rst), .push(irq_push), .din(irq_in), .pop(irq_pop),
        .head(irq_head_raw), .head_valid(irq_vld), .accepted(irq_acc),
        .overflow(irq_ovf));

    rp_msg_fifo #(.WIDTH(ERR_W), .DEPTH(ERR_DEPTH)) u_err_q (
        .clk(clk), .rst(rst), .push(err_push), .din(err_in), .pop(err_pop),
        .head(err_head_raw), .head_valid(err_vld), .accepted(err_acc),
        .overflow(err_ovf));

    rp_msg_regs u_regs (
        .bus_addr(bus_addr), .bus_wr(bus_wr),
        .irq_vld(irq_vld), .irq_head(irq_head),
        .err_vld(err_vld), .err_head(err_head),
        .rdata(bus_rdata), .irq_pop(irq_pop), .err_pop(err_pop));

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_intx <= 1'b0;
            ev_msi  <= 1'b0;
        end else begin
            ev_intx <= irq_acc && !irq_is_msi;
            ev_msi  <= irq_acc && irq_is_msi;
        end
    end

    for (genvar c = 0; c < NUM_ERR_EV; c++) begin : g_err_ev
        always_ff @(posedge clk) begin
            if (rst) ev_err[c] <= 1'b0;
            else     ev_err[c] <= err_acc &&
                                  (class_to_event(err_class_e'(err_class)) == c);
        end
    end

    assert_irq_ev_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_intx, ev_msi}));

    assert_err_ev_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev_err));

    assert_msi_ev_cause_R9: assert property (@(posedge clk) disable iff (rst)
        ev_msi |-> $past(irq_push && irq_is_msi));

    assert_err_ev_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_err != '0) |-> $past(err_push));

endmodule

// File: tb/test_rp_msg_queue.sv
module test_rp_msg_queue;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic irq_push, irq_is_msi, err_push, bus_wr;
    logic [1:0] irq_line, err_class;
    logic [15:0] irq_data, err_rid;
    logic [11:0] bus_addr;
    logic [31:0] bus_rdata;
    logic ev_intx, ev_msi, irq_ovf, err_ovf;
    logic [2:0] ev_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rp_msg_queue i_rp_msg_queue (
        .clk(clk), .rst(rst),
        .irq_push(irq_push), .irq_is_msi(irq_is_msi), .irq_line(irq_line), .irq_data(irq_data),
        .err_push(err_push), .err_class(err_class), .err_rid(err_rid),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .ev_intx(ev_intx), .ev_msi(ev_msi), .ev_err(ev_err),
        .irq_ovf(irq_ovf), .err_ovf(err_ovf));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic push_irq(input logic msi, input logic [1:0] ln, input logic [15:0] d);
        irq_push = 1'b1; irq_is_msi = msi; irq_line = ln; irq_data = d;
        @(negedge clk);
        irq_push = 1'b0;
    endtask

    task automatic push_err(input logic [1:0] c, input logic [15:0] id);
        err_push = 1'b1; err_class = c; err_rid = id;
        @(negedge clk);
        err_push = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a);
        bus_wr = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic [31:0] intx_word(input int ln);
        return 32'h8000_0000 | (32'(ln) << 27);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h158, v); chk("R1 irq head", v, 0);
        rd(12'h15C, v); chk("R1 msi data", v, 0);
        rd(12'h154, v); chk("R1 err head", v, 0);
        chk("R1 events", {ev_intx, ev_msi, ev_err}, 0);
        chk("R1 ovf", {irq_ovf, err_ovf}, 0);
    endtask

    task automatic t_intx_msi();
        logic [31:0] v;
        push_irq(1'b0, 2'd2, 16'hFFFF);
        chk("R9 intx event", {ev_intx, ev_msi}, 2'b10);
        rd(12'h158, v); chk("R2 intx head", v, 32'h9000_0000);
        rd(12'h15C, v); chk("R3 data on intx head", v, 0);
        push_irq(1'b1, 2'd3, 16'h0042);
        chk("R9 msi event", {ev_intx, ev_msi}, 2'b01);
        @(negedge clk);
        chk("R9 pulse ends", {ev_intx, ev_msi}, 2'b00);
        wr(12'h158);
        rd(12'h158, v); chk("R2 msi head", v, 32'hC000_0000);
        rd(12'h15C, v); chk("R3 msi data", v, 32'h0000_0042);
        wr(12'h158);
        rd(12'h158, v); chk("R4 drained", v, 0);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        push_err(2'd1, 16'hABCD);
        chk("R9 nonfatal event", ev_err, 3'b010);
        push_err(2'd2, 16'h1234);
        chk("R9 fatal event", ev_err, 3'b100);
        push_err(2'd0, 16'h0001);
        chk("R9 correctable event", ev_err, 3'b001);
        push_err(2'd3, 16'h0BAD);
        chk("R9 class3 fatal event", ev_err, 3'b100);
        rd(12'h154, v); chk("R5 head1", v, 32'h0005_ABCD);
        wr(12'h154);
        rd(12'h154, v); chk("R5 head2", v, 32'h0006_1234);
        wr(12'h154);
        rd(12'h154, v); chk("R5 head3", v, 32'h0004_0001);
        wr(12'h154);
        rd(12'h154, v); chk("R5 head4", v, 32'h0007_0BAD);
        wr(12'h154);
        rd(12'h154, v); chk("R5 drained", v, 0);
    endtask

    task automatic t_empty_pop();
        logic [31:0] v;
        wr(12'h158);
        wr(12'h154);
        rd(12'h158, v); chk("R6 irq empty", v, 0);
        rd(12'h154, v); chk("R6 err empty", v, 0);
        push_irq(1'b0, 2'd1, 16'h0);
        rd(12'h158, v); chk("R6 push after empty pop", v, 32'h8800_0000);
        wr(12'h158);
        rd(12'h158, v); chk("R6 single entry drained", v, 0);
    endtask

    task automatic t_other_addr();
        logic [31:0] v;
        push_irq(1'b0, 2'd3, 16'h0);
        push_err(2'd0, 16'h5555);
        wr(12'h15C);
        wr(12'h100);
        wr(12'h150);
        rd(12'h158, v); chk("R10 irq head kept", v, 32'h9800_0000);
        rd(12'h154, v); chk("R10 err head kept", v, 32'h0004_5555);
        wr(12'h158);
        wr(12'h154);
        rd(12'h158, v); chk("R10 irq cleanup", v, 0);
    endtask

    task automatic t_full_pop();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) push_irq(1'b0, 2'(i % 4), 16'h0);
        irq_push = 1'b1; irq_is_msi = 1'b1; irq_line = 2'd0; irq_data = 16'h0077;
        bus_wr = 1'b1; bus_addr = 12'h158;
        @(negedge clk);
        irq_push = 1'b0; bus_wr = 1'b0;
        chk("R8 push on full+pop accepted", ev_msi, 1'b1);
        chk("R8 no overflow", irq_ovf, 1'b0);
        for (int i = 1; i < 8; i++) begin
            rd(12'h158, v); chk("R8 order", v, intx_word(i % 4));
            wr(12'h158);
        end
        rd(12'h158, v); chk("R8 new entry last", v, 32'hC000_0000);
        rd(12'h15C, v); chk("R8 new entry data", v, 32'h0000_0077);
        wr(12'h158);
    endtask

    task automatic t_irq_overflow();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) push_irq(1'b0, 2'(3 - (i % 4)), 16'h0);
        chk("R7 not yet overflow", irq_ovf, 1'b0);
        push_irq(1'b1, 2'd0, 16'h0099);
        chk("R7 overflow set", irq_ovf, 1'b1);
        chk("R9 dropped push no event", {ev_intx, ev_msi}, 2'b00);
        for (int i = 0; i < 8; i++) begin
            rd(12'h158, v); chk("R7 stored entries", v, intx_word(3 - (i % 4)));
            wr(12'h158);
        end
        rd(12'h158, v); chk("R7 dropped entry absent", v, 0);
        chk("R7 overflow sticky", irq_ovf, 1'b1);
    endtask

    task automatic t_err_overflow();
        logic [31:0] v;
        chk("R7 err ovf clear", err_ovf, 1'b0);
        for (int i = 0; i < 4; i++) push_err(2'd0, 16'(i + 16'h10));
        push_err(2'd2, 16'hDEAD);
        chk("R7 err overflow set", err_ovf, 1'b1);
        chk("R9 err dropped no event", ev_err, 3'b000);
        for (int i = 0; i < 4; i++) begin
            rd(12'h154, v); chk("R7 err stored", v, 32'h0004_0000 | 32'(i + 16));
            wr(12'h154);
        end
        rd(12'h154, v); chk("R7 err dropped absent", v, 0);
        chk("R7 err overflow sticky", err_ovf, 1'b1);
    endtask

    initial begin
        rst = 1'b1;
        irq_push = 0; irq_is_msi = 0; irq_line = 0; irq_data = 0;
        err_push = 0; err_class = 0; err_rid = 0;
        bus_addr = 0; bus_wr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_intx_msi();
        t_errors();
        t_empty_pop();
        t_other_addr();
        t_full_pop();
        t_irq_overflow();
        t_err_overflow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule